// File: doc/BRIEF.md
# DQS Delay-Tap Calibration Engine

This block searches for the range of delay-tap settings over which a memory interface reads back data correctly, and then centres the tap inside that range. After a start request, it first fills a test region of memory with a fixed pattern. It then tries one candidate tap after another. For each candidate, both byte lanes are set to that tap and the whole region is read back twice. The read data are compared against expected words, which the block regenerates from the read address rather than keeping a stored copy.

The search begins at a seed tap supplied with the start request and climbs first. When the climb hits a failing tap or the ceiling, the block goes back to the seed and descends until it meets a failing tap or reaches zero. Lane 0 is then programmed to the truncated mean of the two passing limits, and lane 1 one tap above it.

Memory is reached through a simple request/acknowledge port that carries one transaction at a time. The delay line and any caching lie outside the block.

Top module: `dqs_tap_cal`

## Requirements
- R1: While reset is asserted and after it is released, busy, done and mem_req are 0 and both tap outputs are 0.
- R2: A start pulse while idle raises busy in the next cycle and latches seed_tap. A start pulse while busy has no effect on the requests issued or on the final taps. No request is issued while busy is low.
- R3: The fill step comes first and runs once per calibration. It writes addresses 0 to WORDS-1 in increasing order. The word at address a, with i = a/4 and k = a mod 4, has bits 15:0 all set when bit 2k of i is 1 and bits 31:16 all set when bit 2k+1 of i is 1, and is 0 elsewhere.
- R4: For each candidate tap, both lanes equal the candidate before its first read and stay there while that check runs. The check reads addresses 0 to WORDS-1 in order, twice. At most one request is outstanding at any time.
- R5: A read whose data differ from the expected word fails the candidate immediately. No further read is issued for that candidate. A mismatch on the second pass counts the same as one on the first.
- R6: Climbing: a passing candidate below the ceiling is followed by candidate+1. A failing candidate sets upper = candidate-1. Either way the next candidate is the seed, and the direction becomes downward.
- R7: Descending (this starts with the seed itself): a passing candidate above 0 is followed by candidate-1. A failing candidate sets lower = candidate+1 and ends the search.
- R8: At the end, tap_lane0 = floor((upper+lower)/2), computed without overflow, and tap_lane1 = tap_lane0+1 (modulo 2^TAP_W).
- R9: done is a single-cycle pulse that coincides with the final tap values, and busy is already low in that cycle.
- R10: A candidate that passes at or above the ceiling MAX_TAP (default 32) sets upper = candidate and ends the climb with no further increment.
- R11: A descending candidate of 0 that passes sets lower = 0 and ends the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration (ignored while busy) |
| seed_tap | input | TAP_W | Starting tap, sampled with start |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| tap_lane0 | output | TAP_W | Delay tap for byte lane 0 |
| tap_lane1 | output | TAP_W | Delay tap for byte lane 1 |
| mem_req | output | 1 | One-cycle request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | IDX_BITS+2 | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Completion of the outstanding request |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |

## Verification
The hardest case to reach from the ports is a candidate that passes its entire first pass and then fails only on the second. A second case that is just as hard is a seed that fails at once, so the same tap is checked twice in a row. The bench memory corrupts a read according to the current lane tap, the address, and which pass the read belongs to. To know the pass, it counts reads since the tap last changed or since the last injected error. This lets one scenario place a single error late in pass two at one chosen tap, and another scenario make the seed fail. In both cases the exact read stream, including where it stops early, is compared against the behavioural model.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;

  typedef enum logic [2:0] {
    SW_IDLE,
    SW_FILL,
    SW_ARM,
    SW_PROBE,
    SW_CENTER
  } sweep_st_t;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_ISSUE,
    MS_WAIT
  } mseq_st_t;

endpackage

// File: rtl/dqs_rst_sync.sv
module dqs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dqs_pat_gen.sv
module dqs_pat_gen #(
  parameter int IDX_BITS = 8,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = IDX_BITS + 2,
  localparam int HALF_W  = DATA_W / 2
) (
  input  logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W-1:0] word
);

  logic [7:0] idx_ext;
  logic [1:0] sub_sel;
  logic [3:0] low_half_on;
  logic [3:0] high_half_on;

  assign idx_ext = 8'(word_addr[ADDR_W-1:2]);
  assign sub_sel = word_addr[1:0];

  for (genvar g = 0; g < 4; g++) begin : g_sub
    assign low_half_on[g]  = idx_ext[2*g];
    assign high_half_on[g] = idx_ext[2*g+1];
  end

  assign word = {{HALF_W{high_half_on[sub_sel]}}, {HALF_W{low_half_on[sub_sel]}}};

endmodule

// File: rtl/dqs_mem_seq.sv
module dqs_mem_seq
  import dqs_cal_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_fill,
  input  logic              go_check,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] expect_word,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              seq_done,
  output logic              seq_fail
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  mseq_st_t          st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              pass_q, pass_d;
  logic              we_q, we_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    pass_d = pass_q;
    we_d   = we_q;
    done_d = 1'b0;
    fail_d = fail_q;
    case (st_q)
      MS_IDLE: begin
        if (go_fill || go_check) begin
          we_d   = go_fill;
          addr_d = '0;
          pass_d = 1'b0;
          st_d   = MS_ISSUE;
        end
      end
      MS_ISSUE: st_d = MS_WAIT;
      MS_WAIT: begin
        if (mem_ack) begin
          if (!we_q && (mem_rdata != expect_word)) begin
            done_d = 1'b1;
            fail_d = 1'b1;
            st_d   = MS_IDLE;
          end else if (addr_q == LAST_ADDR) begin
            if (we_q || pass_q) begin
              done_d = 1'b1;
              fail_d = 1'b0;
              st_d   = MS_IDLE;
            end else begin
              pass_d = 1'b1;
              addr_d = '0;
              st_d   = MS_ISSUE;
            end
          end else begin
            addr_d = addr_q + ADDR_W'(1);
            st_d   = MS_ISSUE;
          end
        end
      end
      default: st_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MS_IDLE;
      addr_q <= '0;
      pass_q <= 1'b0;
      we_q   <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      pass_q <= pass_d;
      we_q   <= we_d;
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign mem_req  = (st_q == MS_ISSUE);
  assign mem_we   = we_q;
  assign mem_addr = addr_q;
  assign seq_done = done_q;
  assign seq_fail = fail_q;

endmodule

// File: rtl/dqs_sweep_ctl.sv
module dqs_sweep_ctl
  import dqs_cal_pkg::*;
#(
  parameter int TAP_W   = 6,
  parameter int MAX_TAP = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAP_W-1:0] seed_tap,
  input  logic             seq_done,
  input  logic             seq_fail,
  output logic             go_fill,
  output logic             go_check,
  output logic             busy,
  output logic             done,
  output logic [TAP_W-1:0] tap0,
  output logic [TAP_W-1:0] tap1
);

  localparam logic [TAP_W-1:0] TAP_CEIL = TAP_W'(MAX_TAP);
  localparam logic [TAP_W-1:0] TAP_ONE  = TAP_W'(1);

  sweep_st_t        st_q, st_d;
  logic [TAP_W-1:0] cand_q, cand_d;
  logic [TAP_W-1:0] home_q, home_d;
  logic [TAP_W-1:0] upper_q, upper_d;
  logic [TAP_W-1:0] lower_q, lower_d;
  logic [TAP_W-1:0] tap0_q, tap0_d;
  logic [TAP_W-1:0] tap1_q, tap1_d;
  logic             climb_q, climb_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             fill_q, fill_d;
  logic             chk_q, chk_d;
  logic [TAP_W:0]   span_sum;
  logic [TAP_W-1:0] centre;

  assign span_sum = {1'b0, upper_q} + {1'b0, lower_q};
  assign centre   = span_sum[TAP_W:1];

  always_comb begin
    st_d    = st_q;
    cand_d  = cand_q;
    home_d  = home_q;
    upper_d = upper_q;
    lower_d = lower_q;
    tap0_d  = tap0_q;
    tap1_d  = tap1_q;
    climb_d = climb_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    fill_d  = 1'b0;
    chk_d   = 1'b0;
    case (st_q)
      SW_IDLE: begin
        if (start) begin
          home_d  = seed_tap;
          cand_d  = seed_tap;
          climb_d = 1'b1;
          busy_d  = 1'b1;
          fill_d  = 1'b1;
          st_d    = SW_FILL;
        end
      end
      SW_FILL: begin
        if (seq_done) st_d = SW_ARM;
      end
      SW_ARM: begin
        tap0_d = cand_q;
        tap1_d = cand_q;
        chk_d  = 1'b1;
        st_d   = SW_PROBE;
      end
      SW_PROBE: begin
        if (seq_done) begin
          if (climb_q) begin
            if (seq_fail) begin
              upper_d = cand_q - TAP_ONE;
              cand_d  = home_q;
              climb_d = 1'b0;
            end else if (cand_q < TAP_CEIL) begin
              cand_d = cand_q + TAP_ONE;
            end else begin
              upper_d = cand_q;
              cand_d  = home_q;
              climb_d = 1'b0;
            end
            st_d = SW_ARM;
          end else begin
            if (seq_fail) begin
              lower_d = cand_q + TAP_ONE;
              st_d    = SW_CENTER;
            end else if (cand_q == '0) begin
              lower_d = '0;
              st_d    = SW_CENTER;
            end else begin
              cand_d = cand_q - TAP_ONE;
              st_d   = SW_ARM;
            end
          end
        end
      end
      SW_CENTER: begin
        tap0_d = centre;
        tap1_d = centre + TAP_ONE;
        done_d = 1'b1;
        busy_d = 1'b0;
        st_d   = SW_IDLE;
      end
      default: st_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SW_IDLE;
      cand_q  <= '0;
      home_q  <= '0;
      upper_q <= '0;
      lower_q <= '0;
      tap0_q  <= '0;
      tap1_q  <= '0;
      climb_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fill_q  <= 1'b0;
      chk_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cand_q  <= cand_d;
      home_q  <= home_d;
      upper_q <= upper_d;
      lower_q <= lower_d;
      tap0_q  <= tap0_d;
      tap1_q  <= tap1_d;
      climb_q <= climb_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      fill_q  <= fill_d;
      chk_q   <= chk_d;
    end
  end

  assign go_fill  = fill_q;
  assign go_check = chk_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign tap0     = tap0_q;
  assign tap1     = tap1_q;

endmodule

// File: rtl/dqs_tap_cal.sv
module dqs_tap_cal #(
  parameter int IDX_BITS = 8,
  parameter int TAP_W    = 6,
  parameter int MAX_TAP  = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = IDX_BITS + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TAP_W-1:0]  seed_tap,
  output logic              busy,
  output logic              done,
  output logic [TAP_W-1:0]  tap_lane0,
  output logic [TAP_W-1:0]  tap_lane1,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              rst_core_n;
  logic              go_fill;
  logic              go_check;
  logic              seq_done;
  logic              seq_fail;
  logic [DATA_W-1:0] pat_word;

  dqs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  dqs_pat_gen #(
    .IDX_BITS (IDX_BITS),
    .DATA_W   (DATA_W)
  ) u_pat (
    .word_addr (mem_addr),
    .word      (pat_word)
  );

  dqs_mem_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .go_fill     (go_fill),
    .go_check    (go_check),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .expect_word (pat_word),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .seq_done    (seq_done),
    .seq_fail    (seq_fail)
  );

  dqs_sweep_ctl #(
    .TAP_W   (TAP_W),
    .MAX_TAP (MAX_TAP)
  ) u_sweep (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (start),
    .seed_tap (seed_tap),
    .seq_done (seq_done),
    .seq_fail (seq_fail),
    .go_fill  (go_fill),
    .go_check (go_check),
    .busy     (busy),
    .done     (done),
    .tap0     (tap_lane0),
    .tap1     (tap_lane1)
  );

  assign mem_wdata = pat_word;

endmodule

// File: rtl/dqs_tap_cal_chk.sv
module dqs_tap_cal_chk #(
  parameter int TAP_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [TAP_W-1:0] tap_lane0,
  input logic [TAP_W-1:0] tap_lane1,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack
);

  logic in_flight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       in_flight <= 1'b0;
    else if (mem_req) in_flight <= 1'b1;
    else if (mem_ack) in_flight <= 1'b0;
  end

  assert_one_in_flight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_flight);

  assert_lanes_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (tap_lane0 == tap_lane1));

  assert_tap_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && !mem_we) |-> $stable(tap_lane0));

  assert_req_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_lane_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tap_lane1 == tap_lane0 + TAP_W'(1)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind dqs_tap_cal dqs_tap_cal_chk #(.TAP_W(TAP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .tap_lane0 (tap_lane0),
  .tap_lane1 (tap_lane1),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack)
);

// File: tb/tb_dqs_tap_cal.sv
module tb_dqs_tap_cal;

  localparam int IDX = 4;
  localparam int TW  = 6;
  localparam int NW  = (1 << IDX) * 4;
  localparam int AW  = IDX + 2;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [TW-1:0] seed_tap;
  logic          busy;
  logic          done;
  logic [TW-1:0] tap_lane0;
  logic [TW-1:0] tap_lane1;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_ack;
  logic [31:0]   mem_rdata;

  dqs_tap_cal #(.IDX_BITS(IDX), .TAP_W(TW), .MAX_TAP(32), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_tap(seed_tap),
    .busy(busy), .done(done), .tap_lane0(tap_lane0), .tap_lane1(tap_lane1),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  typedef struct {
    bit          we;
    int          addr;
    logic [31:0] data;
    int          tap;
  } req_t;

  req_t exp_q[$];

  int win_lo, win_hi, bad_addr, late_tap, late_addr;
  logic [31:0] mem_arr [NW];
  int rd_cnt;
  int last_tap;
  int lat_seq;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_word(int a);
    int i;
    logic [31:0] v;
    i = a / 4;
    v = 32'h0;
    if (((i >> (2 * (a % 4))) & 1) != 0)     v = v | 32'h0000FFFF;
    if (((i >> (2 * (a % 4) + 1)) & 1) != 0) v = v | 32'hFFFF0000;
    return v;
  endfunction

  function automatic bit bad_read(int tap, bit second, int a);
    return ((tap < win_lo || tap > win_hi) && a == bad_addr) ||
           (tap == late_tap && second && a == late_addr);
  endfunction

  // bench memory: one transaction, 1..3 cycle latency, tap-dependent errors
  initial begin
    int pend;
    logic [31:0] pdata;
    pend = 0;
    pdata = '0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_ack = 1'b1;
          mem_rdata = pdata;
        end
      end
      if (mem_req) begin
        if (mem_we) begin
          mem_arr[mem_addr] = mem_wdata;
          pdata = '0;
        end else begin
          bit err;
          if (int'(tap_lane0) != last_tap) begin
            rd_cnt = 0;
            last_tap = int'(tap_lane0);
          end
          err = bad_read(int'(tap_lane0), rd_cnt >= NW, int'(mem_addr));
          pdata = mem_arr[mem_addr] ^ (err ? 32'h1 : 32'h0);
          rd_cnt = err ? 0 : (rd_cnt + 1) % (2 * NW);
        end
        pend = 1 + (lat_seq % 3);
        lat_seq++;
      end
    end
  end

  // behavioural reference: expected request stream and final centre
  task automatic build_model(int seed, output int mid);
    int cand, upper, lower;
    bit climb, fin, failed;
    exp_q.delete();
    for (int a = 0; a < NW; a++) exp_q.push_back('{1'b1, a, ref_word(a), 0});
    cand = seed; climb = 1'b1; fin = 1'b0; upper = 0; lower = 0;
    while (!fin) begin
      failed = 1'b0;
      for (int p = 0; p < 2 && !failed; p++) begin
        for (int a = 0; a < NW && !failed; a++) begin
          exp_q.push_back('{1'b0, a, 32'h0, cand});
          if (bad_read(cand, p == 1, a)) failed = 1'b1;
        end
      end
      if (climb) begin
        if (failed)          begin upper = (cand + 63) % 64; cand = seed; climb = 1'b0; end
        else if (cand < 32)  cand = cand + 1;
        else                 begin upper = cand; cand = seed; climb = 1'b0; end
      end else begin
        if (failed)          begin lower = (cand + 1) % 64; fin = 1'b1; end
        else if (cand == 0)  begin lower = 0; fin = 1'b1; end
        else                 cand = cand - 1;
      end
    end
    mid = (upper + lower) / 2;
  endtask

  task automatic run_scn(string tag, int seed, int lo, int hi, int bad,
                         int ltap, int laddr, bit stray);
    int mid, cyc;
    req_t e;
    win_lo = lo; win_hi = hi; bad_addr = bad; late_tap = ltap; late_addr = laddr;
    rd_cnt = 0; last_tap = -1;
    build_model(seed, mid);
    @(negedge clk);
    start = 1'b1;
    seed_tap = TW'(seed);
    @(negedge clk);
    start = 1'b0;
    seed_tap = '0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (stray && cyc == 40) begin start = 1'b1; seed_tap = 6'd1; end
      if (stray && cyc == 41) begin start = 1'b0; seed_tap = '0; end
      if (mem_req) begin
        chk(busy == 1'b1, "R2", "busy during request", busy, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "request beyond expected stream", mem_addr, 0);
        end else begin
          e = exp_q.pop_front();
          chk(mem_we == e.we, e.we ? "R3" : "R4", "write/read kind", mem_we, e.we);
          chk(int'(mem_addr) == e.addr, e.we ? "R3" : "R5", "address", mem_addr, e.addr);
          if (e.we)
            chk(mem_wdata == e.data, "R3", "fill word", mem_wdata, e.data);
          else begin
            chk(int'(tap_lane0) == e.tap, tag, "lane0 candidate", tap_lane0, e.tap);
            chk(int'(tap_lane1) == e.tap, "R4", "lane1 candidate", tap_lane1, e.tap);
          end
        end
      end
      if (done) break;
      if (cyc > 60000) begin
        chk(1'b0, tag, "scenario watchdog", cyc, 0);
        break;
      end
    end
    chk(exp_q.size() == 0, "R5", "requests left unissued", exp_q.size(), 0);
    chk(int'(tap_lane0) == mid, "R8", {tag, " centre lane0"}, tap_lane0, mid);
    chk(int'(tap_lane1) == (mid + 1) % 64, "R8", "lane1 offset", tap_lane1, (mid + 1) % 64);
    chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", done, 0);
    chk(mem_req == 1'b0, "R2", "no request when idle", mem_req, 0);
  endtask

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL global watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    lat_seq = 0;
    rst_n = 1'b0;
    start = 1'b0;
    seed_tap = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "status in reset", {busy, done}, 0);
    chk(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
    chk(tap_lane0 == '0 && tap_lane1 == '0, "R1", "taps in reset", {tap_lane0, tap_lane1}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && mem_req == 1'b0, "R1", "idle after reset", {busy, mem_req}, 0);
    // R6: climb stops at first fail; stray start during fill must be ignored (R2)
    run_scn("R6", 10, 6, 14, 5, -1, 0, 1'b1);
    // R10 and R11: no failures, climb hits the ceiling, descent reaches zero
    run_scn("R11", 20, 0, 63, 0, -1, 0, 1'b0);
    // R5: error only on the second pass at one tap
    run_scn("R5", 8, 3, 30, 7, 12, 40, 1'b0);
    // R7: seed fails at once, same tap is re-tested going down
    run_scn("R7", 5, 6, 9, 0, -1, 0, 1'b0);
    // R10: seed at the ceiling passes, upper equals the seed
    run_scn("R10", 32, 28, 63, 63, -1, 0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule